// File: doc/BRIEF.md
# Pixel-to-Word Packer and Unpacker

This block sits between a 12-bit pixel source and a 16-bit memory path. On the write side it gathers four pixels into a 48-bit group and sends that group out as three 16-bit words, so the memory stores every pixel bit and pads nothing. On the read side a matching unpacker takes groups of three words and returns the four pixels in their original order. Both sides use valid/ready handshakes. The write side stalls its pixel input when its word output cannot drain.

A frame-start flag travels with the pixel that opens a frame. It forces that pixel into the first slot of a fresh group, so groups realign at every frame. A frame-end flag on the last pixel closes the group early. Any empty slots are filled with zeros. Frame flags come out on the word and pixel outputs, so the stream can be split back into frames after the memory.

Top module: `pixel_word_packer`

## Requirements
- R1: Within a group, pixel k (k = 0..3 in arrival order) occupies group bits [12k+11:12k]. Word j (j = 0..2) carries group bits [16j+15:16j], and the words leave in the order j = 0, 1, 2.
- R2: A pixel accepted with inEof high closes its group at once. Pixel slots that were not filled are sent as zero.
- R3: A pixel accepted with inSof high is placed in slot 0 of a new group. Any pixels of an unfinished group received before it are discarded.
- R4: While outValid is high and outReady is low, inReady is low.
- R5: Every pixel accepted into a group that is completed appears exactly once at the word output, and once again at the pixel output of the loop through the unpacker. Nothing is lost or duplicated. While outValid is high and outReady is low, outWord holds steady. While pixValid is high and pixReady is low, pixOut holds steady.
- R6: When outReady and pixReady stay high, the block accepts one pixel in every cycle with no gap.
- R7: The unpacker treats three accepted words as group bits [15:0], [31:16], [47:32]. It emits the four 12-bit pixels of that group starting with bits [11:0] and moving upward.
- R8: During and right after reset, outValid and pixValid are low, and inReady and wordReady are high.
- R9: outSof is high only on word 0 of a group whose first pixel carried inSof. outEof is high only on word 2 of a group closed by inEof. pixSof is high only on pixel 0 of a group whose first word carried wordSof.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inPix | input | 12 | Pixel into the packer |
| inValid | input | 1 | Pixel valid |
| inReady | output | 1 | Packer accepts a pixel |
| inSof | input | 1 | Pixel opens a frame |
| inEof | input | 1 | Pixel closes a frame |
| outWord | output | 16 | Packed memory word |
| outValid | output | 1 | Word valid |
| outReady | input | 1 | Downstream accepts a word |
| outSof | output | 1 | Word 0 of the first group of a frame |
| outEof | output | 1 | Word 2 of the last group of a frame |
| wordIn | input | 16 | Memory word into the unpacker |
| wordValid | input | 1 | Word valid |
| wordReady | output | 1 | Unpacker accepts a word |
| wordSof | input | 1 | Word opens a frame |
| pixOut | output | 12 | Rebuilt pixel |
| pixValid | output | 1 | Pixel valid |
| pixReady | input | 1 | Downstream accepts a pixel |
| pixSof | output | 1 | First pixel of a frame |

## Verification
The bench builds the block with its default values: 12-bit pixels, 16-bit words and four pixels per group. With these values pixel 1 spans words 0 and 1, and pixel 2 spans words 1 and 2, so every split boundary of the 4:3 conversion is exercised. The packer output is looped into the unpacker through a random stall gate. Frames of 1 to 13 pixels therefore reach every fill level of a closing group, and random back-pressure on both outputs hits both the stall path and the early-close path.

// File: rtl/pwp_pkg.sv
package pwp_pkg;
  localparam int IDX_W = 4;

  typedef struct packed {
    logic             take;     // pixel accepted this cycle
    logic             newGrp;   // pixel opens a fresh group
    logic             load;     // group complete, move to output stage
    logic             pending;  // output stage holds words
    logic [IDX_W-1:0] slot;     // slot the accepted pixel lands in
    logic [IDX_W-1:0] wordIdx;  // word currently offered
  } packStrobe_t;
endpackage

// File: rtl/pwp_pack_ctrl.sv
module pwp_pack_ctrl
  import pwp_pkg::*;
#(
  parameter int PIX_PER_GRP = 4,
  parameter int WORDS       = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic        inSof,
  input  logic        inEof,
  input  logic        outReady,
  output logic        inReady,
  output logic        outValid,
  output packStrobe_t st
);
  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(PIX_PER_GRP - 1);
  localparam logic [IDX_W-1:0] LAST_WORD = IDX_W'(WORDS - 1);

  logic [IDX_W-1:0] phase, wordIdx, slot;
  logic pending, closes, lastWord, handoffOk, take, load, advance;

  always_comb begin
    slot      = inSof ? '0 : phase;
    closes    = (slot == LAST_SLOT) || inEof;
    lastWord  = (wordIdx == LAST_WORD);
    handoffOk = !pending || (outReady && lastWord);
    inReady   = (!pending || outReady) && (!closes || handoffOk);
    take      = inValid && inReady;
    load      = take && closes;
    advance   = pending && outReady;
    outValid  = pending;
    st.take    = take;
    st.newGrp  = (slot == '0);
    st.load    = load;
    st.pending = pending;
    st.slot    = slot;
    st.wordIdx = wordIdx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= '0;
      pending <= 1'b0;
      wordIdx <= '0;
    end else begin
      if (take) phase <= closes ? '0 : slot + IDX_W'(1);
      if (load) begin
        pending <= 1'b1;
        wordIdx <= '0;
      end else if (advance) begin
        if (lastWord) pending <= 1'b0;
        else          wordIdx <= wordIdx + IDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/pwp_pack_dp.sv
module pwp_pack_dp
  import pwp_pkg::*;
#(
  parameter int PIX_W       = 12,
  parameter int WORD_W      = 16,
  parameter int PIX_PER_GRP = 4,
  parameter int WORDS       = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  packStrobe_t       st,
  input  logic [PIX_W-1:0]  inPix,
  input  logic              inSof,
  input  logic              inEof,
  output logic [WORD_W-1:0] outWord,
  output logic              outSof,
  output logic              outEof
);
  localparam int GRP_W = PIX_W * PIX_PER_GRP;
  localparam logic [IDX_W-1:0] LAST_WORD = IDX_W'(WORDS - 1);

  logic [GRP_W-1:0] acc, accNext, outGrp;
  logic accSof, grpSof, grpEof, nextSof;

  always_comb begin
    accNext = st.newGrp ? '0 : acc;
    accNext[st.slot*PIX_W +: PIX_W] = inPix;
    nextSof = st.newGrp ? inSof : accSof;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      outGrp <= '0;
      accSof <= 1'b0;
      grpSof <= 1'b0;
      grpEof <= 1'b0;
    end else begin
      if (st.take) begin
        acc    <= accNext;
        accSof <= nextSof;
      end
      if (st.load) begin
        outGrp <= accNext;
        grpSof <= nextSof;
        grpEof <= inEof;
      end
    end
  end

  always_comb begin
    outWord = outGrp[st.wordIdx*WORD_W +: WORD_W];
    outSof  = st.pending && grpSof && (st.wordIdx == '0);
    outEof  = st.pending && grpEof && (st.wordIdx == LAST_WORD);
  end
endmodule

// File: rtl/pwp_unpack.sv
module pwp_unpack
  import pwp_pkg::*;
#(
  parameter int PIX_W       = 12,
  parameter int WORD_W      = 16,
  parameter int PIX_PER_GRP = 4,
  parameter int WORDS       = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] wordIn,
  input  logic              wordValid,
  input  logic              wordSof,
  output logic              wordReady,
  output logic [PIX_W-1:0]  pixOut,
  output logic              pixValid,
  input  logic              pixReady,
  output logic              pixSof
);
  localparam int GRP_W = PIX_W * PIX_PER_GRP;
  localparam int ACC_W = GRP_W - WORD_W;
  localparam logic [IDX_W-1:0] LAST_WORD = IDX_W'(WORDS - 1);
  localparam logic [IDX_W-1:0] LAST_PIX  = IDX_W'(PIX_PER_GRP - 1);

  logic [ACC_W-1:0] acc;
  logic [GRP_W-1:0] outGrp;
  logic [IDX_W-1:0] widx, wslot, pidx;
  logic accSof, grpSof, pend, wComplete, handoffOk, wTake;

  always_comb begin
    wslot     = wordSof ? '0 : widx;
    wComplete = (wslot == LAST_WORD);
    handoffOk = !pend || (pixReady && (pidx == LAST_PIX));
    wordReady = !wComplete || handoffOk;
    wTake     = wordValid && wordReady;
    pixOut    = outGrp[pidx*PIX_W +: PIX_W];
    pixValid  = pend;
    pixSof    = pend && grpSof && (pidx == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      outGrp <= '0;
      widx   <= '0;
      pidx   <= '0;
      accSof <= 1'b0;
      grpSof <= 1'b0;
      pend   <= 1'b0;
    end else begin
      if (wTake && !wComplete) begin
        acc[wslot*WORD_W +: WORD_W] <= wordIn;
        if (wslot == '0) accSof <= wordSof;
        widx <= wslot + IDX_W'(1);
      end
      if (wTake && wComplete) begin
        widx   <= '0;
        outGrp <= {wordIn, acc};
        grpSof <= (wslot == '0) ? wordSof : accSof;
        pend   <= 1'b1;
        pidx   <= '0;
      end else if (pend && pixReady) begin
        if (pidx == LAST_PIX) pend <= 1'b0;
        else                  pidx <= pidx + IDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/pixel_word_packer.sv
module pixel_word_packer
  import pwp_pkg::*;
#(
  parameter int PIX_W       = 12,
  parameter int WORD_W      = 16,
  parameter int PIX_PER_GRP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PIX_W-1:0]  inPix,
  input  logic              inValid,
  output logic              inReady,
  input  logic              inSof,
  input  logic              inEof,
  output logic [WORD_W-1:0] outWord,
  output logic              outValid,
  input  logic              outReady,
  output logic              outSof,
  output logic              outEof,
  input  logic [WORD_W-1:0] wordIn,
  input  logic              wordValid,
  output logic              wordReady,
  input  logic              wordSof,
  output logic [PIX_W-1:0]  pixOut,
  output logic              pixValid,
  input  logic              pixReady,
  output logic              pixSof
);
  localparam int WORDS = (PIX_W * PIX_PER_GRP) / WORD_W;

  packStrobe_t st;

  pwp_pack_ctrl #(.PIX_PER_GRP(PIX_PER_GRP), .WORDS(WORDS)) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inSof(inSof), .inEof(inEof),
    .outReady(outReady), .inReady(inReady), .outValid(outValid), .st(st)
  );

  pwp_pack_dp #(.PIX_W(PIX_W), .WORD_W(WORD_W), .PIX_PER_GRP(PIX_PER_GRP),
                .WORDS(WORDS)) u_dp (
    .clk(clk), .rst(rst), .st(st), .inPix(inPix), .inSof(inSof),
    .inEof(inEof), .outWord(outWord), .outSof(outSof), .outEof(outEof)
  );

  pwp_unpack #(.PIX_W(PIX_W), .WORD_W(WORD_W), .PIX_PER_GRP(PIX_PER_GRP),
               .WORDS(WORDS)) u_unpack (
    .clk(clk), .rst(rst), .wordIn(wordIn), .wordValid(wordValid),
    .wordSof(wordSof), .wordReady(wordReady), .pixOut(pixOut),
    .pixValid(pixValid), .pixReady(pixReady), .pixSof(pixSof)
  );
endmodule

// File: rtl/pwp_checker.sv
module pwp_checker #(
  parameter int PIX_W  = 12,
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              inReady,
  input logic [WORD_W-1:0] outWord,
  input logic              outValid,
  input logic              outReady,
  input logic              outSof,
  input logic              outEof,
  input logic [PIX_W-1:0]  pixOut,
  input logic              pixValid,
  input logic              pixReady,
  input logic              pixSof
);
  // R4
  stall_blocks_input_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |-> !inReady);

  // R5
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outWord)));

  // R5
  pix_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pixValid && !pixReady) |=> (pixValid && $stable(pixOut)));

  // R9
  word_marks_chk: assert property (@(posedge clk) disable iff (rst)
    (outSof || outEof) |-> outValid);

  // R9
  pix_mark_chk: assert property (@(posedge clk) disable iff (rst)
    pixSof |-> pixValid);
endmodule

bind pixel_word_packer pwp_checker #(.PIX_W(PIX_W), .WORD_W(WORD_W)) i_chk (
  .clk(clk), .rst(rst), .inReady(inReady), .outWord(outWord),
  .outValid(outValid), .outReady(outReady), .outSof(outSof), .outEof(outEof),
  .pixOut(pixOut), .pixValid(pixValid), .pixReady(pixReady), .pixSof(pixSof)
);

// File: tb/test_pixel_word_packer.sv
`timescale 1ns/1ps
module test_pixel_word_packer;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst;
  logic [11:0] inPix;
  logic        inValid, inSof, inEof, inReady;
  logic [15:0] outWord;
  logic        outValid, outReady, outSof, outEof;
  logic        wordValid, wordReady;
  logic [11:0] pixOut;
  logic        pixValid, pixReady, pixSof;
  logic        gate;

  assign wordValid = outValid && gate;
  assign outReady  = wordReady && gate;

  pixel_word_packer i_pixel_word_packer (
    .clk(clk), .rst(rst), .inPix(inPix), .inValid(inValid), .inReady(inReady),
    .inSof(inSof), .inEof(inEof), .outWord(outWord), .outValid(outValid),
    .outReady(outReady), .outSof(outSof), .outEof(outEof), .wordIn(outWord),
    .wordValid(wordValid), .wordReady(wordReady), .wordSof(outSof),
    .pixOut(pixOut), .pixValid(pixValid), .pixReady(pixReady), .pixSof(pixSof)
  );

  int nChk = 0, nFail = 0;
  int validPct = 100, gatePct = 100, rdyPct = 100;
  bit thru = 0, lastAcc = 0;

  logic [13:0] srcQ[$];
  logic [17:0] expWQ[$];
  string       expWT[$];
  logic [12:0] expPQ[$];
  logic [11:0] cur[$];
  bit curSof = 0, curDrop = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [47:0] buildGrp(input logic [11:0] p0, p1, p2, p3);
    return {p3, p2, p1, p0};
  endfunction

  task automatic modelPush(input logic [11:0] p, input bit s, input bit e);
    logic [47:0] g;
    string tag;
    if (s) begin
      curDrop = (cur.size() > 0);
      cur.delete();
    end
    cur.push_back(p);
    if (cur.size() == 1) curSof = s;
    if (cur.size() == 4 || e) begin
      tag = curDrop ? "R3" : (cur.size() < 4 ? "R2" : "R1");
      while (cur.size() < 4) cur.push_back(12'h000);
      g = buildGrp(cur[0], cur[1], cur[2], cur[3]);
      for (int w = 0; w < 3; w++) begin
        expWQ.push_back({bit'(w == 0 && curSof), bit'(w == 2 && e), g[16*w +: 16]});
        expWT.push_back(tag);
      end
      for (int k = 0; k < 4; k++) expPQ.push_back({bit'(k == 0 && curSof), cur[k]});
      cur.delete();
      curDrop = 0;
    end
  endtask

  task automatic step();
    logic [17:0] ew;
    logic [12:0] ep;
    string t;
    @(negedge clk);
    if (lastAcc) begin inValid = 0; lastAcc = 0; end
    if (!inValid && srcQ.size() > 0 && $urandom_range(99) < validPct) begin
      {inSof, inEof, inPix} = srcQ.pop_front();
      inValid = 1;
    end
    gate     = ($urandom_range(99) < gatePct);
    pixReady = ($urandom_range(99) < rdyPct);
    #1;
    if (outValid && !outReady) chk(!inReady, "R4", "inReady during word stall", inReady, 0);
    if (thru && inValid) chk(inReady, "R6", "inReady in full-rate stream", inReady, 1);
    if (inValid && inReady) begin
      modelPush(inPix, inSof, inEof);
      lastAcc = 1;
    end
    if (wordValid && wordReady) begin
      if (expWQ.size() == 0) chk(0, "R5", "unexpected word", outWord, 0);
      else begin
        ew = expWQ.pop_front();
        t  = expWT.pop_front();
        chk(outWord == ew[15:0], t, "word data", outWord, ew[15:0]);
        chk({outSof, outEof} == ew[17:16], "R9", "word markers", {outSof, outEof}, ew[17:16]);
      end
    end
    if (pixValid && pixReady) begin
      if (expPQ.size() == 0) chk(0, "R5", "unexpected pixel", pixOut, 0);
      else begin
        ep = expPQ.pop_front();
        chk(pixOut == ep[11:0], "R7", "pixel data", pixOut, ep[11:0]);
        chk(pixSof == ep[12], "R9", "pixel frame mark", pixSof, ep[12]);
      end
    end
  endtask

  task automatic addFrame(input int n);
    for (int i = 0; i < n; i++)
      srcQ.push_back({bit'(i == 0), bit'(i == n - 1), 12'($urandom)});
  endtask

  task automatic drain();
    int guard = 0;
    while ((srcQ.size() > 0 || inValid || expWQ.size() > 0 || expPQ.size() > 0)
           && guard < 5000) begin
      step();
      guard++;
    end
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        nChk++; nFail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", nChk - nFail, nChk);
        $finish;
      end
    join_none
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1; inPix = 0; inValid = 0; inSof = 0; inEof = 0; gate = 1; pixReady = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8 state held in reset
    chk(!outValid, "R8", "outValid in reset", outValid, 0);
    chk(!pixValid, "R8", "pixValid in reset", pixValid, 0);
    chk(inReady, "R8", "inReady in reset", inReady, 1);
    chk(wordReady, "R8", "wordReady in reset", wordReady, 1);
    rst = 0;
    @(negedge clk);
    chk(!outValid && !pixValid && inReady && wordReady, "R8", "state after reset",
        {outValid, pixValid, inReady, wordReady}, 4'b0011);

    // R1 directed full groups
    srcQ.push_back({2'b10, 12'h123}); srcQ.push_back({2'b00, 12'h456});
    srcQ.push_back({2'b00, 12'h789}); srcQ.push_back({2'b00, 12'hABC});
    srcQ.push_back({2'b00, 12'hFFF}); srcQ.push_back({2'b00, 12'h000});
    srcQ.push_back({2'b00, 12'h5A5}); srcQ.push_back({2'b01, 12'hA5A});
    drain();

    // R6 sustained rate with all downstream ready
    thru = 1; addFrame(40); drain(); thru = 0;

    // R2 short frames that end mid group
    addFrame(1); addFrame(2); addFrame(3); addFrame(5); addFrame(6); drain();

    // R3 frame start after an unfinished group
    srcQ.push_back({2'b00, 12'h111}); srcQ.push_back({2'b00, 12'h222});
    srcQ.push_back({2'b10, 12'h333}); srcQ.push_back({2'b00, 12'h444});
    srcQ.push_back({2'b00, 12'h555}); srcQ.push_back({2'b01, 12'h666});
    drain();

    // R4 word output blocked for a while
    gatePct = 0; addFrame(12);
    repeat (20) step();
    gatePct = 100; drain();

    // random mix
    for (int f = 0; f < 80; f++) begin
      validPct = 30 + $urandom_range(70);
      gatePct  = 30 + $urandom_range(70);
      rdyPct   = 30 + $urandom_range(70);
      addFrame(1 + $urandom_range(12));
      drain();
    end
    validPct = 100; gatePct = 100; rdyPct = 100;
    drain();

    // R5 every expected word and pixel arrived
    chk(expWQ.size() == 0 && expPQ.size() == 0 && srcQ.size() == 0, "R5",
        "leftover items", expWQ.size() + expPQ.size() + srcQ.size(), 0);
    repeat (4) step();
    chk(!outValid && !pixValid, "R5", "no extra output", {outValid, pixValid}, 0);

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule